// File: doc/BRIEF.md
# Tick-Based Weighted Round-Robin Arbiter

This block shares one resource among four requesting clients. A free-running divider turns the system clock into arbitration ticks, and each client owns an 8-bit weight that sets how many ticks one grant may last. A grant is held for that many ticks as long as the client keeps requesting. When the weight is used up, the search for the next owner starts at the client after the current holder and wraps around, so the holder is considered last.

An enable input and the request lines gate the whole machine. If the enable is low, or if no client is requesting, the arbiter falls back to an idle state. From idle, the lowest-numbered requester wins. The registered grant is one-hot. A state code, a keep-client flag and a one-cycle grant-change pulse let surrounding logic follow the arbitration.

Top module: `wrr_tick_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant`, `state_o`, `keep_client` and `grant_switch` are all zero.
- R2: `grant` is registered and one-hot or zero, and bit n-1 stands for client n. `state_o` is 0 in the idle state and n while client n holds the grant.
- R3: If `arb_en` is low or `req` is all zero at a clock edge, the arbiter is idle after that edge. While `arb_en` stays low, requests are ignored and the grant stays zero.
- R4: From the idle state with `arb_en` high, the lowest-numbered requesting client is granted at the next edge.
- R5: A client that keeps requesting holds the grant for exactly weight × period clock cycles. The tick and weight counters restart with every new grant. `keep_client` is high during the grant except in its final cycle, and it is zero when idle.
- R6: When a grant expires with client n as holder, the next owner is the first requester in the order n+1, n+2, n+3, wrapping from 4 to 1, with n last. A sole requester is granted again without a switch pulse.
- R7: A weight of 0 counts as 1 tick, and a tick period of 0 counts as 1 clock.
- R8: If the holder drops its request while other clients still request, the grant moves at the next edge to the next requester in rotated order.
- R9: `grant_switch` is high for exactly the first cycle after each change of `grant`, including changes to and from idle.
- R10: The weight of client n is `weights[8n-1:8(n-1)]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | Arbiter enable |
| req | input | 4 | Request lines, bit n-1 for client n |
| weights | input | 32 | Packed per-client tick weights, 8 bits each |
| tick_period | input | 8 | System clocks per arbitration tick |
| grant | output | 4 | Registered one-hot grant |
| state_o | output | 3 | 0 when idle, n while client n holds the grant |
| keep_client | output | 1 | Current holder keeps the grant past this cycle |
| grant_switch | output | 1 | One-cycle pulse after each grant change |

## Verification
The bound checker watches the following on every cycle:
- the one-hot grant and its agreement with the state code;
- the forced return to idle;
- lowest-index selection out of idle;
- holding while `keep_client` is high and the holder still requests;
- the move away from a holder that stops requesting;
- the pulse that accompanies every grant change.

Some behaviours are only visible over whole scenarios in the bench:
- exact hold lengths in cycles for given weights and periods, including zero weights and a zero period;
- the rotation order across the wrap from client 4 to client 1;
- re-granting a sole requester.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_C1   = 3'd1,
      ST_C2   = 3'd2,
      ST_C3   = 3'd3,
      ST_C4   = 3'd4
   } arb_state_e;

   localparam int unsigned CLIENTS = 4;
endpackage

// File: rtl/wrr_tick_gen.sv
module wrr_tick_gen #(
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                restart,
   input  logic [PERIOD_W-1:0] period,
   output logic                tick
);
   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W-1:0] per_eff;

   // a zero period behaves as one clock per tick
   assign per_eff = (period == '0) ? PERIOD_W'(1) : period;
   assign tick    = run && (cnt_q == per_eff - PERIOD_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart || !run)   cnt_q <= '0;
      else if (tick)              cnt_q <= '0;
      else                        cnt_q <= cnt_q + PERIOD_W'(1);
   end
endmodule

// File: rtl/wrr_weight_cnt.sv
module wrr_weight_cnt #(
   parameter int unsigned WEIGHT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                restart,
   input  logic                tick,
   input  logic [WEIGHT_W-1:0] weight,
   output logic                keep
);
   logic [WEIGHT_W-1:0] used_q;
   logic [WEIGHT_W-1:0] w_eff;
   logic                last_tick;

   // a zero weight still earns one tick
   assign w_eff     = (weight == '0) ? WEIGHT_W'(1) : weight;
   assign last_tick = tick && (used_q == w_eff - WEIGHT_W'(1));
   assign keep      = run && !last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               used_q <= '0;
      else if (restart || !run) used_q <= '0;
      else if (tick)            used_q <= used_q + WEIGHT_W'(1);
   end
endmodule

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
   parameter int unsigned N     = 4,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   input  logic             idle,
   input  logic [IDX_W-1:0] holder,
   output logic             found,
   output logic [IDX_W-1:0] win
);
   int unsigned start;
   int unsigned idx;

   always_comb begin
      found = 1'b0;
      win   = '0;
      idx   = 0;
      start = idle ? 0 : (int'(holder) + 1) % N;
      for (int i = 0; i < N; i++) begin
         idx = (start + i) % N;
         if (!found && req[idx]) begin
            found = 1'b1;
            win   = IDX_W'(idx);
         end
      end
   end
endmodule

// File: rtl/wrr_tick_arbiter.sv
module wrr_tick_arbiter
   import wrr_pkg::*;
#(
   parameter int unsigned N_CLIENTS = 4,
   parameter int unsigned WEIGHT_W  = 8,
   parameter int unsigned PERIOD_W  = 8,
   localparam int unsigned IDX_W    = $clog2(N_CLIENTS),
   localparam int unsigned WBUS_W   = N_CLIENTS * WEIGHT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arb_en,
   input  logic [N_CLIENTS-1:0] req,
   input  logic [WBUS_W-1:0]    weights,
   input  logic [PERIOD_W-1:0]  tick_period,
   output logic [N_CLIENTS-1:0] grant,
   output logic [2:0]           state_o,
   output logic                 keep_client,
   output logic                 grant_switch
);
   if (N_CLIENTS != CLIENTS) begin : g_bad_clients
      $error("wrr_tick_arbiter: state encoding supports exactly four clients");
   end
   if (WEIGHT_W < 1 || PERIOD_W < 1) begin : g_bad_widths
      $error("wrr_tick_arbiter: counter widths must be positive");
   end

   arb_state_e           st_q, st_d;
   logic [2:0]           st_bits;
   logic [IDX_W-1:0]     hidx;
   logic                 run, holder_req, reeval, tick, keep, found;
   logic [IDX_W-1:0]     win;
   logic [WEIGHT_W-1:0]  w_arr [N_CLIENTS];
   logic [WEIGHT_W-1:0]  w_sel;
   logic [N_CLIENTS-1:0] grant_q;
   logic                 switch_q;

   for (genvar g = 0; g < N_CLIENTS; g++) begin : g_wsplit
      assign w_arr[g] = weights[g*WEIGHT_W +: WEIGHT_W];
   end

   assign st_bits    = st_q;
   assign run        = (st_q != ST_IDLE);
   assign hidx       = run ? IDX_W'(st_bits - 3'd1) : '0;
   assign w_sel      = w_arr[hidx];
   assign holder_req = run && req[hidx];
   assign reeval     = !run || !keep || !holder_req;

   wrr_tick_gen #(.PERIOD_W(PERIOD_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (reeval),
      .period  (tick_period),
      .tick    (tick)
   );

   wrr_weight_cnt #(.WEIGHT_W(WEIGHT_W)) u_wcnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (reeval),
      .tick    (tick),
      .weight  (w_sel),
      .keep    (keep)
   );

   wrr_rr_pick #(.N(N_CLIENTS)) u_pick (
      .req    (req),
      .idle   (!run),
      .holder (hidx),
      .found  (found),
      .win    (win)
   );

   always_comb begin
      if (!arb_en || req == '0) st_d = ST_IDLE;
      else if (!reeval)         st_d = st_q;
      else if (found)           st_d = arb_state_e'(3'(win) + 3'd1);
      else                      st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         grant_q  <= '0;
         switch_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         grant_q  <= (st_d == ST_IDLE) ? '0
                   : N_CLIENTS'(1) << (3'(st_d) - 3'd1);
         switch_q <= (st_d != st_q);
      end
   end

   assign grant        = grant_q;
   assign state_o      = st_bits;
   assign keep_client  = keep;
   assign grant_switch = switch_q;
endmodule

// File: rtl/wrr_tick_arbiter_chk.sv
module wrr_tick_arbiter_chk #(
   parameter int unsigned N_CLIENTS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 arb_en,
   input logic [N_CLIENTS-1:0] req,
   input logic [N_CLIENTS-1:0] grant,
   input logic [2:0]           state_o,
   input logic                 keep_client,
   input logic                 grant_switch
);
   // R1
   always_comb begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (grant == '0 && state_o == 3'd0 && !grant_switch);
      end
   end

   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r2_state_match: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 3'd0) |-> (grant == (N_CLIENTS'(1) << (state_o - 3'd1))));

   a_r3_force_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!arb_en || req == '0) |=> (grant == '0 && state_o == 3'd0));

   a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0 && arb_en && req != '0)
      |=> (grant == ($past(req) & (~$past(req) + N_CLIENTS'(1)))));

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_client && arb_en && (grant & req) != '0)
      |=> ($stable(grant) && !grant_switch));

   a_r5_idle_no_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd0) |-> !keep_client);

   a_r8_drop_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 3'd0 && arb_en && req != '0 && (grant & req) == '0)
      |=> (grant != $past(grant) && (grant & $past(req)) != '0));

   a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != $past(grant)) |-> grant_switch);

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == $past(grant)) |-> !grant_switch);
endmodule

bind wrr_tick_arbiter wrr_tick_arbiter_chk #(.N_CLIENTS(N_CLIENTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arb_en       (arb_en),
   .req          (req),
   .grant        (grant),
   .state_o      (state_o),
   .keep_client  (keep_client),
   .grant_switch (grant_switch)
);

// File: tb/wrr_tick_arbiter_tb_top.sv
`timescale 1ns/1ps
module wrr_tick_arbiter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        arb_en;
   logic [3:0]  req;
   logic [31:0] weights;
   logic [7:0]  tick_period;
   logic [3:0]  grant;
   logic [2:0]  state_o;
   logic        keep_client;
   logic        grant_switch;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   bit sb_on    = 1'b0;

   typedef struct {
      logic [3:0] g;
      int         len;
      string      tag;
   } seg_t;
   seg_t exp_q[$];

   always #2 clk = ~clk;

   wrr_tick_arbiter dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .arb_en       (arb_en),
      .req          (req),
      .weights      (weights),
      .tick_period  (tick_period),
      .grant        (grant),
      .state_o      (state_o),
      .keep_client  (keep_client),
      .grant_switch (grant_switch)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // length 0 accepts any length
   task automatic push_seg(input logic [3:0] g, input int len, input string tag);
      seg_t s;
      s.g = g; s.len = len; s.tag = tag;
      exp_q.push_back(s);
   endtask

   // monitor: samples 1 ns after each rising edge
   logic [3:0] prev_g = 4'b0;
   int         seg_len = 0;
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (grant != prev_g) begin
            if (prev_g != 4'b0 && sb_on) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R6", "unexpected grant segment", int'(prev_g), 0);
               end else begin
                  seg_t e;
                  e = exp_q.pop_front();
                  chk(prev_g == e.g, e.tag, "segment owner", int'(prev_g), int'(e.g));
                  if (e.len != 0)
                     chk(seg_len == e.len, e.tag, "segment length", seg_len, e.len);
               end
            end
            seg_len = 1;
         end else begin
            seg_len++;
         end
         chk(grant_switch == (grant != prev_g), "R9", "switch pulse",
             int'(grant_switch), int'(grant != prev_g));
         chk((state_o == 3'd0) ? (grant == 4'b0) : (grant == (4'b1 << (state_o - 3'd1))),
             "R2", "state/grant agreement", int'(grant), int'(state_o));
         if (grant == 4'b0)
            chk(!keep_client, "R5", "keep low when idle", int'(keep_client), 0);
         prev_g = grant;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input string tag);
      req = 4'b0;
      cyc(4);
      chk(exp_q.size() == 0, tag, "expected segments left", exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      rst_n = 1'b0; arb_en = 1'b0; req = 4'b0; weights = '0; tick_period = '0;
      cyc(3);
      chk(grant == 4'b0,   "R1", "grant in reset",  int'(grant), 0);
      chk(state_o == 3'd0, "R1", "state in reset",  int'(state_o), 0);
      chk(!keep_client,    "R1", "keep in reset",   int'(keep_client), 0);
      chk(!grant_switch,   "R1", "switch in reset", int'(grant_switch), 0);
      rst_n = 1'b1;
      cyc(2);

      // R10 packing, R5 hold length, R6 rotation
      arb_en = 1'b1; tick_period = 8'd5;
      weights = {8'd17, 8'd20, 8'd1, 8'd3};
      sb_on = 1'b1;
      push_seg(4'b0001, 15,  "R10");
      push_seg(4'b0010, 5,   "R5");
      push_seg(4'b0100, 100, "R10");
      push_seg(4'b0001, 15,  "R6");
      push_seg(4'b0010, 5,   "R6");
      push_seg(4'b0100, 0,   "R6");
      req = 4'b0111;
      cyc(14);
      chk(keep_client,  "R5", "keep high mid grant", int'(keep_client), 1);
      cyc(1);
      chk(!keep_client, "R5", "keep low in last cycle", int'(keep_client), 0);
      cyc(130);
      drain("R5");

      // R7 zero weights
      tick_period = 8'd3; weights = 32'h0;
      push_seg(4'b0001, 3, "R7");
      push_seg(4'b1000, 3, "R7");
      push_seg(4'b0001, 3, "R7");
      push_seg(4'b1000, 0, "R7");
      req = 4'b1001;
      cyc(10);
      drain("R7");

      // R7 zero period, R6 wrap
      tick_period = 8'd0; weights = {8'd1, 8'd3, 8'd1, 8'd2};
      push_seg(4'b0001, 2, "R7");
      push_seg(4'b0010, 1, "R6");
      push_seg(4'b0100, 3, "R7");
      push_seg(4'b1000, 1, "R6");
      push_seg(4'b0001, 2, "R6");
      push_seg(4'b0010, 0, "R6");
      req = 4'b1111;
      cyc(10);
      drain("R6");

      // R8 holder drops, then R6 sole requester re-granted
      tick_period = 8'd4; weights = 32'h0A0A0A0A;
      push_seg(4'b0010, 7, "R8");
      push_seg(4'b0100, 0, "R6");
      req = 4'b0110;
      cyc(7);
      req = 4'b0100;
      cyc(60);
      chk(grant == 4'b0100, "R6", "sole requester kept", int'(grant), 4);
      drain("R8");

      // R8 drop with wrap from client 4 to client 1
      tick_period = 8'd2; weights = 32'h05050505;
      push_seg(4'b1000, 3, "R8");
      push_seg(4'b0001, 0, "R8");
      req = 4'b1000;
      cyc(3);
      req = 4'b0011;
      cyc(3);
      drain("R8");

      // R3 / R4 / R9 direct
      sb_on = 1'b0;
      weights = 32'h04040404;
      req = 4'b0011;
      cyc(1);
      chk(grant == 4'b0001, "R4", "lowest requester wins", int'(grant), 1);
      arb_en = 1'b0;
      cyc(1);
      chk(grant == 4'b0000, "R3", "disable forces idle", int'(grant), 0);
      chk(state_o == 3'd0,  "R3", "idle state code", int'(state_o), 0);
      req = 4'b1100;
      cyc(3);
      chk(grant == 4'b0000, "R3", "requests ignored while disabled", int'(grant), 0);
      arb_en = 1'b1;
      cyc(1);
      chk(grant == 4'b0100, "R4", "fixed order from idle", int'(grant), 4);
      chk(grant_switch,     "R9", "pulse on new grant", int'(grant_switch), 1);
      cyc(1);
      chk(!grant_switch,    "R9", "pulse lasts one cycle", int'(grant_switch), 0);
      req = 4'b0000;
      cyc(1);
      chk(grant == 4'b0000, "R3", "no requests forces idle", int'(grant), 0);
      req = 4'b1010;
      cyc(1);
      chk(grant == 4'b0010, "R4", "lowest of 1010", int'(grant), 2);
      req = 4'b0000;
      cyc(3);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule